// File: doc/BRIEF.md
# Flash Bank Status Register Unit

This unit keeps the status byte of one bank of a flash memory controller. It accepts single-cycle command strobes for program start, erase start, suspend, resume and clear-status. It also contains a small stand-in for the program/erase engine. The stand-in runs for a fixed number of cycles, pauses a fixed number of cycles after a suspend, and at the end of an operation reports the verify result that was sampled when the operation began. The programming-voltage-valid input is sampled once, when an operation is accepted.

A bus read is active when chip enable and output enable are both low. At the edge where a read becomes active, the unit captures the live status byte and holds it until one of the enables goes high again. A fresh read is therefore needed to see a newer value. While the bank is busy, the bus data output carries the captured status in place of array data.

Top module: `flash_bank_status`

## Requirements
- R1: After reset the captured status byte reads 0x80 and the bus carries array data. Bits 1 and 0 of the status byte always read 0.
- R2: Bit 7 (ready) is 0 from the cycle after a program or erase is accepted until the operation ends or pauses. It is 1 when the bank is idle or suspended.
- R3: A suspend accepted during an operation leaves bit 7 at 0 for SUSP_LAT cycles, which is at most SUSP_US×CLK_MHZ cycles. Then bit 7 returns to 1, and bit 6 is set if the suspended operation is an erase, or bit 2 if it is a program. Resume clears bits 6 and 2 and makes the bank busy again until the remaining cycles have run.
- R4: If the operation's remaining time ends before the pause is due, the operation completes normally: bit 7 returns to 1 and neither bit 6 nor bit 2 is set.
- R5: An operation that ends with a verify failure sets bit 5 if it is an erase, or bit 4 if it is a program.
- R6: A program or erase issued while the voltage-valid input is low sets bit 3 and is refused: the bank never becomes busy.
- R7: Bits 5, 4 and 3 stay set until a clear-status command or reset.
- R8: A program or erase issued while bit 5, 4 or 3 is set is refused: the bank stays ready. The refused command sets its own failure bit (bit 4 for a program, bit 5 for an erase).
- R9: The status byte is captured when the condition "chip enable low and output enable low" becomes true. The captured value is held while both stay low, even if the live status changes.
- R10: While bit 7 of the live status is 0, bus_out equals the captured status. Otherwise bus_out equals arr_data.
- R11: Suspend is ignored unless an operation is running. Resume is ignored unless the bank is suspended. Program and erase are ignored while the bank is busy or suspended. Clear-status does not change bits 7, 6 or 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_prog | input | 1 | Program start strobe |
| cmd_erase | input | 1 | Erase start strobe |
| cmd_susp | input | 1 | Suspend strobe |
| cmd_resume | input | 1 | Resume strobe |
| cmd_clr | input | 1 | Clear-status strobe |
| vpp_ok | input | 1 | Programming voltage valid, sampled at operation start |
| verify_fail | input | 1 | Stub engine: operation will end failing, sampled at start |
| ce_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Output enable, active low |
| arr_data | input | 8 | Array data for reads while ready |
| stat_out | output | 8 | Captured status byte |
| bus_out | output | 8 | Read data: captured status when busy, else array data |

## Verification
The hardest case to reach is the race between a suspend and the end of the operation. For completion to win, the suspend must arrive fewer than SUSP_LAT cycles before the engine's last run cycle. The stimulus counts cycles from the accepted program and issues the suspend three cycles before the end. It then checks that the bank comes back ready with neither suspend bit set. A second hard case is a read that stays active across the end of an operation. The stimulus holds both enables low through completion and checks that the captured busy byte stays unchanged until the enables are toggled.

// File: rtl/fbs_pkg.sv
// Shared types and bit positions for the flash bank status unit.
package fbs_pkg;
    typedef enum logic [1:0] {ENG_IDLE, ENG_RUN, ENG_PEND, ENG_HALT} eng_state_e;
    typedef enum logic {OP_PROG, OP_ERASE} op_kind_e;

    localparam int unsigned BIT_READY = 7;
    localparam int unsigned BIT_ESUS  = 6;
    localparam int unsigned BIT_EFAIL = 5;
    localparam int unsigned BIT_PFAIL = 4;
    localparam int unsigned BIT_VLOW  = 3;
    localparam int unsigned BIT_PSUS  = 2;
    localparam logic [7:0]  STAT_RESET = 8'h80;
endpackage

// File: rtl/fbs_engine.sv
// Stand-in for the program/erase engine.
// An accepted operation runs OP_LAT cycles. A suspend moves it to a pending
// state in which it keeps running. It pauses after SUSP_LAT cycles unless the
// run ends first. Resume continues from the saved run count.
// Assumes OP_LAT >= 2, SUSP_LAT >= 1 and SUSP_LAT <= SUSP_MAX.
module fbs_engine
    import fbs_pkg::*;
#(
    parameter int unsigned OP_LAT   = 40,
    parameter int unsigned SUSP_LAT = 10,
    parameter int unsigned SUSP_MAX = 3000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start_go,
    input  op_kind_e   start_kind,
    input  logic       susp_cmd,
    input  logic       resume_cmd,
    input  logic       verify_fail,
    output eng_state_e state,
    output op_kind_e   kind,
    output logic       fin,
    output logic       fin_fail
);
    localparam int unsigned RW = $clog2(OP_LAT + 1);
    localparam int unsigned PW = $clog2(SUSP_LAT + 1);
    localparam int unsigned MW = $clog2(SUSP_MAX + 2);

    logic [RW-1:0] run_cnt;
    logic [PW-1:0] pause_cnt;
    logic          fail_q;
    logic          run_last;
    logic          pause_last;

    // End-of-run and end-of-pause detection.
    assign run_last   = (run_cnt == RW'(OP_LAT - 1));
    assign pause_last = (pause_cnt == PW'(SUSP_LAT - 1));
    assign fin        = ((state == ENG_RUN) || (state == ENG_PEND)) && run_last;
    assign fin_fail   = fin && fail_q;

    // Operation state, run counter and pause counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ENG_IDLE;
            kind      <= OP_PROG;
            run_cnt   <= '0;
            pause_cnt <= '0;
            fail_q    <= 1'b0;
        end else begin
            unique case (state)
                ENG_IDLE: if (start_go) begin
                    state   <= ENG_RUN;
                    kind    <= start_kind;
                    run_cnt <= '0;
                    fail_q  <= verify_fail;
                end
                ENG_RUN: if (run_last) begin
                    state <= ENG_IDLE;
                end else begin
                    run_cnt <= run_cnt + 1'b1;
                    if (susp_cmd) begin
                        state     <= ENG_PEND;
                        pause_cnt <= '0;
                    end
                end
                ENG_PEND: if (run_last) begin
                    state <= ENG_IDLE;
                end else begin
                    run_cnt <= run_cnt + 1'b1;
                    if (pause_last) state <= ENG_HALT;
                    else            pause_cnt <= pause_cnt + 1'b1;
                end
                ENG_HALT: if (resume_cmd) state <= ENG_RUN;
                default: state <= ENG_IDLE;
            endcase
        end
    end

    // Separate count of the cycles spent pending, used by the bound check.
    logic [MW-1:0] wait_cnt;
    always_ff @(posedge clk) begin
        if (!rst_n)                  wait_cnt <= '0;
        else if (state != ENG_PEND)  wait_cnt <= '0;
        else if (wait_cnt != '1)     wait_cnt <= wait_cnt + 1'b1;
    end

    p_susp_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ENG_PEND) |-> (wait_cnt < MW'(SUSP_MAX)));

    p_resume_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ENG_HALT && resume_cmd) |=> (state == ENG_RUN));

    p_idle_susp_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ENG_IDLE && !start_go) |=> (state == ENG_IDLE));
endmodule

// File: rtl/fbs_errs.sv
// Sticky error flags: erase failure, program failure and low voltage.
// A flag is set by a failing completion or by a refused start. Flags are
// cleared only by the clear command or reset; a set in the same cycle wins.
module fbs_errs
    import fbs_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     clr,
    input  logic     fin_fail,
    input  op_kind_e run_kind,
    input  logic     refuse_err,
    input  logic     refuse_vpp,
    input  op_kind_e req_kind,
    output logic     efail_q,
    output logic     pfail_q,
    output logic     vlow_q,
    output logic     any_err
);
    logic set_e, set_p;

    // Set conditions from the engine result and from refused starts.
    assign set_e   = (fin_fail && run_kind == OP_ERASE) || (refuse_err && req_kind == OP_ERASE);
    assign set_p   = (fin_fail && run_kind == OP_PROG)  || (refuse_err && req_kind == OP_PROG);
    assign any_err = efail_q || pfail_q || vlow_q;

    // Sticky flag registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            efail_q <= 1'b0;
            pfail_q <= 1'b0;
            vlow_q  <= 1'b0;
        end else begin
            efail_q <= (efail_q && !clr) || set_e;
            pfail_q <= (pfail_q && !clr) || set_p;
            vlow_q  <= (vlow_q  && !clr) || refuse_vpp;
        end
    end

    p_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && any_err) |=>
        ((efail_q || !$past(efail_q)) && (pfail_q || !$past(pfail_q)) && (vlow_q || !$past(vlow_q))));
endmodule

// File: rtl/fbs_readout.sv
// Read-out capture: takes the live status when a read becomes active
// (both enables low) and holds it while the read stays active.
// Busy status also steers the bus from array data to the captured byte.
module fbs_readout
    import fbs_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ce_n,
    input  logic       oe_n,
    input  logic [7:0] live,
    input  logic [7:0] arr_data,
    output logic [7:0] stat_out,
    output logic [7:0] bus_out
);
    logic en_act, en_prev;
    logic [7:0] hold_q;

    assign en_act   = !ce_n && !oe_n;
    assign stat_out = hold_q;
    // Bus source: captured status while busy, array data otherwise.
    assign bus_out  = live[BIT_READY] ? arr_data : hold_q;

    // Enable history and capture register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_prev <= 1'b0;
            hold_q  <= STAT_RESET;
        end else begin
            en_prev <= en_act;
            if (en_act && !en_prev) hold_q <= live;
        end
    end

    p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (en_act && en_prev) |=> $stable(hold_q));

    p_reserved_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (en_act && !en_prev) |=> (hold_q[1:0] == 2'b00));
endmodule

// File: rtl/flash_bank_status.sv
// Status register unit for one flash bank.
// It decides whether a start command is accepted or refused, drives the
// stub engine and the sticky flags, builds the live status byte and hands
// it to the read-out capture. Commands are one-cycle strobes; when program
// and erase arrive together, program takes precedence.
module flash_bank_status
    import fbs_pkg::*;
#(
    parameter int unsigned OP_LAT   = 40,
    parameter int unsigned SUSP_LAT = 10,
    parameter int unsigned CLK_MHZ  = 100,
    parameter int unsigned SUSP_US  = 30
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cmd_prog,
    input  logic       cmd_erase,
    input  logic       cmd_susp,
    input  logic       cmd_resume,
    input  logic       cmd_clr,
    input  logic       vpp_ok,
    input  logic       verify_fail,
    input  logic       ce_n,
    input  logic       oe_n,
    input  logic [7:0] arr_data,
    output logic [7:0] stat_out,
    output logic [7:0] bus_out
);
    localparam int unsigned SUSP_MAX = CLK_MHZ * SUSP_US;

    eng_state_e eng_state;
    op_kind_e   run_kind, req_kind;
    logic       fin, fin_fail;
    logic       attempt, refuse_vpp, refuse_err, start_go;
    logic       efail_q, pfail_q, vlow_q, any_err;
    logic [7:0] live;

    // Start decision: only an idle bank takes a start; voltage and errors gate it.
    assign req_kind   = cmd_prog ? OP_PROG : OP_ERASE;
    assign attempt    = (cmd_prog || cmd_erase) && (eng_state == ENG_IDLE);
    assign refuse_vpp = attempt && !vpp_ok;
    assign refuse_err = attempt && any_err;
    assign start_go   = attempt && vpp_ok && !any_err;

    // Live status byte assembly.
    always_comb begin
        live            = 8'h00;
        live[BIT_READY] = (eng_state == ENG_IDLE) || (eng_state == ENG_HALT);
        live[BIT_ESUS]  = (eng_state == ENG_HALT) && (run_kind == OP_ERASE);
        live[BIT_PSUS]  = (eng_state == ENG_HALT) && (run_kind == OP_PROG);
        live[BIT_EFAIL] = efail_q;
        live[BIT_PFAIL] = pfail_q;
        live[BIT_VLOW]  = vlow_q;
    end

    fbs_engine #(
        .OP_LAT  (OP_LAT),
        .SUSP_LAT(SUSP_LAT),
        .SUSP_MAX(SUSP_MAX)
    ) u_engine (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_go   (start_go),
        .start_kind (req_kind),
        .susp_cmd   (cmd_susp),
        .resume_cmd (cmd_resume),
        .verify_fail(verify_fail),
        .state      (eng_state),
        .kind       (run_kind),
        .fin        (fin),
        .fin_fail   (fin_fail)
    );

    fbs_errs u_errs (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (cmd_clr),
        .fin_fail  (fin_fail),
        .run_kind  (run_kind),
        .refuse_err(refuse_err),
        .refuse_vpp(refuse_vpp),
        .req_kind  (req_kind),
        .efail_q   (efail_q),
        .pfail_q   (pfail_q),
        .vlow_q    (vlow_q),
        .any_err   (any_err)
    );

    fbs_readout u_readout (
        .clk     (clk),
        .rst_n   (rst_n),
        .ce_n    (ce_n),
        .oe_n    (oe_n),
        .live    (live),
        .arr_data(arr_data),
        .stat_out(stat_out),
        .bus_out (bus_out)
    );

    p_refuse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (attempt && any_err) |=> (eng_state == ENG_IDLE));

    p_vpp_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (attempt && !vpp_ok) |=> (vlow_q && eng_state == ENG_IDLE));

    p_fin_ready_r2: assert property (@(posedge clk) disable iff (!rst_n)
        fin |=> (eng_state == ENG_IDLE));
endmodule

// File: tb/test_flash_bank_status.sv
// Scoreboard bench: driver tasks queue expected read results, a monitor
// pops them and compares one cycle after the capture edge.
module test_flash_bank_status;
    localparam int unsigned OP_LAT   = 40;
    localparam int unsigned SUSP_LAT = 10;
    localparam logic [7:0]  ARR      = 8'h3C;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cmd_prog = 0, cmd_erase = 0, cmd_susp = 0, cmd_resume = 0, cmd_clr = 0;
    logic vpp_ok = 1'b1, verify_fail = 1'b0;
    logic ce_n = 1'b1, oe_n = 1'b1;
    logic [7:0] arr_data = ARR;
    logic [7:0] stat_out, bus_out;

    always #5 clk = ~clk;

    flash_bank_status #(.OP_LAT(OP_LAT), .SUSP_LAT(SUSP_LAT), .CLK_MHZ(100), .SUSP_US(30))
    i_flash_bank_status (
        .clk(clk), .rst_n(rst_n), .cmd_prog(cmd_prog), .cmd_erase(cmd_erase),
        .cmd_susp(cmd_susp), .cmd_resume(cmd_resume), .cmd_clr(cmd_clr),
        .vpp_ok(vpp_ok), .verify_fail(verify_fail), .ce_n(ce_n), .oe_n(oe_n),
        .arr_data(arr_data), .stat_out(stat_out), .bus_out(bus_out)
    );

    typedef struct {
        logic [7:0] s;
        logic [7:0] b;
        string      tag;
    } item_t;
    item_t q[$];
    int n_chk = 0, n_bad = 0;
    bit done = 0;

    // Monitor: compare each queued item at the negedge after its push.
    initial begin
        forever begin
            item_t it;
            wait (q.size() != 0);
            it = q.pop_front();
            @(negedge clk);
            n_chk++;
            if (stat_out !== it.s || bus_out !== it.b) begin
                n_bad++;
                $display("FAIL %s: stat=%02h exp=%02h bus=%02h exp=%02h",
                         it.tag, stat_out, it.s, bus_out, it.b);
            end
        end
    end

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic expect_now(input logic [7:0] s, input logic [7:0] b, input string tag);
        item_t it;
        it.s = s; it.b = b; it.tag = tag;
        q.push_back(it);
        @(negedge clk);
    endtask

    task automatic rd(input logic [7:0] s, input logic [7:0] b, input string tag);
        ce_n = 1'b0; oe_n = 1'b0;
        expect_now(s, b, tag);
        @(negedge clk);
        oe_n = 1'b1;
        @(negedge clk);
    endtask

    // Command strobe: 0 prog, 1 erase, 2 suspend, 3 resume, 4 clear.
    task automatic send(input int c);
        case (c)
            0: cmd_prog = 1'b1;
            1: cmd_erase = 1'b1;
            2: cmd_susp = 1'b1;
            3: cmd_resume = 1'b1;
            default: cmd_clr = 1'b1;
        endcase
        @(negedge clk);
        cmd_prog = 0; cmd_erase = 0; cmd_susp = 0; cmd_resume = 0; cmd_clr = 0;
    endtask

    // Watchdog.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: run did not end, exp=finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        idle(4);
        rst_n = 1'b1;
        idle(1);
        rd(8'h80, ARR, "R1 reset value, reserved bits zero");

        // Program runs, then completes.
        send(0);
        rd(8'h00, 8'h00, "R2 R10 busy during program");
        idle(OP_LAT);
        rd(8'h80, ARR, "R2 ready after program");

        // Read held across completion.
        send(0);
        ce_n = 1'b0; oe_n = 1'b0;
        expect_now(8'h00, 8'h00, "R9 capture busy");
        idle(OP_LAT + 2);
        expect_now(8'h00, ARR, "R9 held after completion, R10 array when ready");
        oe_n = 1'b1;
        idle(1);
        rd(8'h80, ARR, "R9 refresh after toggle");

        // Program verify failure.
        verify_fail = 1'b1;
        send(0);
        verify_fail = 1'b0;
        idle(OP_LAT + 2);
        rd(8'h90, ARR, "R5 program failure bit 4");

        // Refusal with sticky error set.
        send(0);
        rd(8'h90, ARR, "R8 program refused, stays ready");
        send(1);
        rd(8'hB0, ARR, "R8 erase refused sets bit 5");
        idle(6);
        rd(8'hB0, ARR, "R7 sticky bits hold");
        send(4);
        rd(8'h80, ARR, "R7 clear-status");

        // Erase verify failure.
        verify_fail = 1'b1;
        send(1);
        verify_fail = 1'b0;
        idle(OP_LAT + 2);
        rd(8'hA0, ARR, "R5 erase failure bit 5");
        send(4);

        // Low programming voltage.
        vpp_ok = 1'b0;
        send(1);
        vpp_ok = 1'b1;
        rd(8'h88, ARR, "R6 voltage low refused, bit 3");
        send(4);
        rd(8'h80, ARR, "R7 clear after voltage error");

        // Erase suspend and resume.
        send(1);
        idle(3);
        send(2);
        rd(8'h00, 8'h00, "R3 busy while suspend pending");
        idle(SUSP_LAT);
        rd(8'hC0, ARR, "R3 erase suspended bit 6");
        send(4);
        rd(8'hC0, ARR, "R11 clear keeps bits 7 6");
        send(2);
        rd(8'hC0, ARR, "R11 suspend while suspended ignored");
        send(0);
        rd(8'hC0, ARR, "R11 program while suspended ignored");
        send(3);
        rd(8'h00, 8'h00, "R3 resume makes busy");
        idle(OP_LAT);
        rd(8'h80, ARR, "R3 resumed erase completes");

        // Program suspend.
        send(0);
        send(2);
        idle(SUSP_LAT + 1);
        rd(8'h84, ARR, "R3 program suspended bit 2");
        send(3);
        idle(OP_LAT + 2);
        rd(8'h80, ARR, "R3 resumed program completes");

        // Completion wins the race against suspend.
        send(0);
        idle(OP_LAT - 4);
        send(2);
        idle(4);
        rd(8'h80, ARR, "R4 completion beats suspend");
        idle(SUSP_LAT);
        rd(8'h80, ARR, "R4 no suspend state later");

        // Suspend and resume with nothing to act on.
        send(3);
        rd(8'h80, ARR, "R11 resume when idle ignored");
        send(2);
        rd(8'h80, ARR, "R11 suspend when idle ignored");

        // Simultaneous program and erase: program taken.
        verify_fail = 1'b1;
        cmd_prog = 1'b1; cmd_erase = 1'b1;
        @(negedge clk);
        cmd_prog = 1'b0; cmd_erase = 1'b0; verify_fail = 1'b0;
        idle(OP_LAT + 2);
        rd(8'h90, ARR, "R5 program wins tie");

        idle(3);
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule